// File: doc/BRIEF.md
# SPI Register Access Port

This block lets an external SPI master read and write a bank of 21 eight-bit control and status registers. The master pulls chip select low and sends a command byte first. That byte names one of 32 register numbers, gives the transfer direction and can carry an acknowledge request. Any number of data bytes follow, and each one is written into the chosen register or read out of it. The SPI pins are sampled with the system clock. SCK idles low, the block captures MOSI on the rising SCK edge and moves MISO on the falling edge.

A mode input selects what MISO carries during the command byte. In full-duplex mode it carries a live byte of eight interrupt status inputs. In half-duplex mode it carries zeros, and software then reads those status bits as ordinary register bits. Every write to the bank also appears on a parallel port as a one-cycle strobe with its address and data. The read data of the addressed register is shown on the same port. Register 20 holds four general-purpose input pins in its upper nibble, and register 9 holds the acknowledge flag.

Top module: `spi_regport`

## Requirements
- R1: Bytes move most significant bit first in both directions; MOSI is captured on rising SCK and MISO changes only after falling SCK, so its first bit is valid before the first rising edge.
- R2: Command byte fields: bits 7..3 register number (bit 7 most significant), bit 2 reserved and ignored, bit 1 direction, bit 0 acknowledge request.
- R3: With direction 1, every data byte after the command is written into the addressed register and produces exactly one `bank_wr` pulse carrying that address and byte.
- R4: With direction 0, every data byte after the command returns the current contents of the addressed register on MISO.
- R5: A command byte with bit 0 set sets bit 0 of register 9; bit 0 clear leaves it unchanged. Software clears it by writing register 9.
- R6: In full-duplex mode (`full_duplex`=1) MISO carries `usb_status[7]` down to `usb_status[0]` during the command byte.
- R7: In half-duplex mode (`full_duplex`=0) MISO is 0 during the command byte.
- R8: Register 20 bits 7..4 show `gp_in[3:0]` through a two-flop synchronizer; writes to those bits are ignored, and bits 3..0 are ordinary storage.
- R9: Register numbers 21 to 31 read as 0, and writes to them produce no `bank_wr` pulse and change nothing.
- R10: Raising chip select during a byte abandons it; the next byte after chip select falls again is decoded as a command.
- R11: After reset every register is 0, `bank_wr` is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| full_duplex | input | 1 | 1: status byte during the command byte, 0: zeros |
| usb_status | input | 8 | Live interrupt status bits |
| gp_in | input | 4 | General-purpose input pins |
| bank_wr | output | 1 | One-cycle write strobe |
| bank_addr | output | 5 | Register number of the current transfer |
| bank_wdata | output | 8 | Byte being written |
| bank_rdata | output | 8 | Contents of the addressed register |

## Verification
SPI pins pass through a two-flop synchronizer and an edge register. A write strobe therefore appears about three clocks after the rising SCK edge that ends the byte, and MISO moves about three clocks after each falling edge. MISO holds the first status bit within three clocks of chip select falling. The bench holds every SCK level for six clocks and samples MISO on the falling clock edge just before it raises SCK, which leaves at least three clocks of margin on every bit. A monitor counts write strobes, and the register contents are checked by reading them back over SPI.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
   localparam int CMD_W        = 8;
   localparam int CMD_ADDR_W   = 5;
   localparam int CMD_ADDR_LSB = 3;
   localparam int CMD_DIR_POS  = 1;
   localparam int CMD_ACK_POS  = 0;

   typedef enum logic {
      PH_COMMAND = 1'b0,
      PH_PAYLOAD = 1'b1
   } frame_phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = STAGES * W;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync needs at least two stages");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS = 21
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sck_s,
   input  logic                  csn_s,
   input  logic                  mosi_s,
   input  logic                  full_duplex,
   input  logic [CMD_W-1:0]      status_in,
   input  logic [CMD_W-1:0]      rd_data,
   output logic                  miso,
   output logic                  wr_en,
   output logic [CMD_ADDR_W-1:0] addr,
   output logic [CMD_W-1:0]      wr_data,
   output logic                  ack_set
);
   localparam int                 CNT_W = $clog2(CMD_W);
   localparam logic [CMD_ADDR_W:0] LIMIT = (CMD_ADDR_W+1)'(NUM_REGS);

   logic                  sck_d, csn_d;
   logic [CNT_W-1:0]      bit_cnt;
   logic [CMD_W-2:0]      sh_in;
   logic [CMD_W-1:0]      sh_out;
   frame_phase_e          phase;
   logic [CMD_ADDR_W-1:0] cmd_addr;
   logic                  cmd_dir;

   logic                  sck_rise, sck_fall, cs_start, last_bit, mapped;
   logic [CMD_W-1:0]      byte_in;

   assign sck_rise = sck_s & ~sck_d & ~csn_s;
   assign sck_fall = ~sck_s & sck_d & ~csn_s;
   assign cs_start = csn_d & ~csn_s;
   assign last_bit = (bit_cnt == CNT_W'(CMD_W-1));
   assign byte_in  = {sh_in, mosi_s};
   assign mapped   = ({1'b0, cmd_addr} < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         csn_d    <= 1'b1;
         bit_cnt  <= '0;
         sh_in    <= '0;
         sh_out   <= '0;
         phase    <= PH_COMMAND;
         cmd_addr <= '0;
         cmd_dir  <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         ack_set  <= 1'b0;
      end else begin
         sck_d   <= sck_s;
         csn_d   <= csn_s;
         wr_en   <= 1'b0;
         ack_set <= 1'b0;
         if (csn_s) begin
            bit_cnt <= '0;
            phase   <= PH_COMMAND;
            sh_out  <= '0;
         end else begin
            if (cs_start) sh_out <= full_duplex ? status_in : '0;
            if (sck_rise) begin
               bit_cnt <= bit_cnt + 1'b1;
               sh_in   <= byte_in[CMD_W-2:0];
               if (last_bit) begin
                  if (phase == PH_COMMAND) begin
                     cmd_addr <= byte_in[CMD_W-1 -: CMD_ADDR_W];
                     cmd_dir  <= byte_in[CMD_DIR_POS];
                     ack_set  <= byte_in[CMD_ACK_POS];
                     phase    <= PH_PAYLOAD;
                  end else if (cmd_dir && mapped) begin
                     wr_en   <= 1'b1;
                     wr_data <= byte_in;
                  end
               end
            end
            if (sck_fall) begin
               if (bit_cnt == '0)
                  sh_out <= (phase == PH_PAYLOAD && !cmd_dir) ? rd_data : '0;
               else
                  sh_out <= {sh_out[CMD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = sh_out[CMD_W-1];
   assign addr = cmd_addr;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
   parameter int NUM_REGS = 21,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 5,
   parameter int ACK_REG  = 9,
   parameter int ACK_BIT  = 0,
   parameter int GPIN_REG = 20,
   parameter int GPIN_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_set,
   input  logic [GPIN_W-1:0] gpin_s,
   output logic [DATA_W-1:0] rd_data,
   output logic              ack_flag,
   output logic [GPIN_W-1:0] gp_field
);
   localparam int LOW_W = DATA_W - GPIN_W;

   logic [DATA_W-1:0] reg_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(i));
      if (i == GPIN_REG) begin : g_gpin
         logic [LOW_W-1:0] low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   low_q <= '0;
            else if (hit) low_q <= wr_data[LOW_W-1:0];
         end
         assign reg_q[i] = {gpin_s, low_q};
      end else if (i == ACK_REG) begin : g_ack
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else begin
               if (hit)     q          <= wr_data;
               if (ack_set) q[ACK_BIT] <= 1'b1;
            end
         end
         assign reg_q[i] = q;
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
         assign reg_q[i] = q;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (addr == ADDR_W'(i)) rd_data = reg_q[i];
   end

   assign ack_flag = reg_q[ACK_REG][ACK_BIT];
   assign gp_field = reg_q[GPIN_REG][DATA_W-1 -: GPIN_W];
endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS    = 21,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int ACK_REG     = 9,
   parameter int ACK_BIT     = 0,
   parameter int GPIN_REG    = 20,
   parameter int GPIN_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              full_duplex,
   input  logic [DATA_W-1:0] usb_status,
   input  logic [GPIN_W-1:0] gp_in,
   output logic              bank_wr,
   output logic [ADDR_W-1:0] bank_addr,
   output logic [DATA_W-1:0] bank_wdata,
   output logic [DATA_W-1:0] bank_rdata
);
   if (DATA_W != CMD_W || ADDR_W != CMD_ADDR_W) begin : g_bad_layout
      $error("command layout needs 8-bit data and a 5-bit register number");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("register count does not fit the register number field");
   end
   if (ACK_REG >= NUM_REGS || GPIN_REG >= NUM_REGS || ACK_REG == GPIN_REG) begin : g_bad_map
      $error("special registers out of range or overlapping");
   end
   if (ACK_BIT >= DATA_W || GPIN_W < 1 || GPIN_W >= DATA_W) begin : g_bad_fields
      $error("special field positions out of range");
   end

   logic              sck_s, csn_s, mosi_s;
   logic [GPIN_W-1:0] gpin_s;
   logic              ack_set, ack_flag;
   logic [GPIN_W-1:0] gp_field;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_csn, spi_mosi}),
      .q     ({sck_s, csn_s, mosi_s})
   );

   spi_sync #(.W(GPIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gp_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gp_in),
      .q     (gpin_s)
   );

   spi_frame_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sck_s       (sck_s),
      .csn_s       (csn_s),
      .mosi_s      (mosi_s),
      .full_duplex (full_duplex),
      .status_in   (usb_status),
      .rd_data     (bank_rdata),
      .miso        (spi_miso),
      .wr_en       (bank_wr),
      .addr        (bank_addr),
      .wr_data     (bank_wdata),
      .ack_set     (ack_set)
   );

   spi_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .ACK_REG  (ACK_REG),
      .ACK_BIT  (ACK_BIT),
      .GPIN_REG (GPIN_REG),
      .GPIN_W   (GPIN_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr),
      .addr     (bank_addr),
      .wr_data  (bank_wdata),
      .ack_set  (ack_set),
      .gpin_s   (gpin_s),
      .rd_data  (bank_rdata),
      .ack_flag (ack_flag),
      .gp_field (gp_field)
   );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
   parameter int NUM_REGS    = 21,
   parameter int ADDR_W      = 5,
   parameter int ACK_REG     = 9,
   parameter int GPIN_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bank_wr,
   input logic [ADDR_W-1:0] bank_addr,
   input logic              ack_set,
   input logic              ack_flag,
   input logic [GPIN_W-1:0] gp_in,
   input logic [GPIN_W-1:0] gp_field
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
   end

   // R9: no strobe ever targets a register number outside the bank
   assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |-> ({1'b0, bank_addr} < (ADDR_W+1)'(NUM_REGS)));

   // R3: each written byte gives a single-cycle strobe
   assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |=> !bank_wr);

   // R5: the acknowledge flag only rises after a command request or a write to its register
   assert_ack_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_flag) |->
         ($past(ack_set) || ($past(bank_wr) && $past(bank_addr) == ADDR_W'(ACK_REG))));

   // R8: the pin field follows the pins two clocks later
   if (SYNC_STAGES == 2) begin : g_gp_chk
      assert_gp_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (gp_field == $past(gp_in, 2)));
   end
endmodule

bind spi_regport spi_regport_chk #(
   .NUM_REGS    (NUM_REGS),
   .ADDR_W      (ADDR_W),
   .ACK_REG     (ACK_REG),
   .GPIN_W      (GPIN_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bank_wr   (bank_wr),
   .bank_addr (bank_addr),
   .ack_set   (ack_set),
   .ack_flag  (ack_flag),
   .gp_in     (gp_in),
   .gp_field  (gp_field)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso;
   logic       full_duplex = 1'b0;
   logic [7:0] usb_status = 8'h00;
   logic [3:0] gp_in = 4'h0;
   logic       bank_wr;
   logic [4:0] bank_addr;
   logic [7:0] bank_wdata, bank_rdata;

   int n_run = 0, n_fail = 0, wr_cnt = 0;
   logic [4:0] last_a;
   logic [7:0] last_d;

   always #5 clk = ~clk;

   spi_regport i_spi_regport (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .full_duplex(full_duplex),
      .usb_status(usb_status), .gp_in(gp_in), .bank_wr(bank_wr),
      .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
   );

   always @(posedge clk) if (bank_wr) begin
      wr_cnt = wr_cnt + 1;
      last_a = bank_addr;
      last_d = bank_wdata;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cmd(input logic [4:0] a, input logic dir, input logic ack);
      return {a, 1'b0, dir, ack};
   endfunction

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         spi_mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cs_low();
      spi_csn = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (HALF) @(negedge clk);
      spi_csn = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic write_reg(input logic [4:0] a, input logic [7:0] d);
      logic [7:0] rx;
      cs_low();
      spi_bits(cmd(a, 1'b1, 1'b0), 8, rx);
      spi_bits(d, 8, rx);
      cs_high();
   endtask

   task automatic read_reg(input logic [4:0] a, output logic [7:0] d);
      logic [7:0] rx;
      cs_low();
      spi_bits(cmd(a, 1'b0, 1'b0), 8, rx);
      spi_bits(8'h00, 8, d);
      cs_high();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check(spi_miso == 1'b0, "R11 miso", spi_miso, 0);
      check(bank_wr == 1'b0, "R11 strobe", bank_wr, 0);
      read_reg(5'd0, d);
      check(d == 8'h00, "R11 reg0", d, 0);
      read_reg(5'd9, d);
      check(d == 8'h00, "R11 reg9", d, 0);
   endtask

   task automatic t_write_read();
      logic [7:0] d, rx;
      int c0 = wr_cnt;
      write_reg(5'd3, 8'hA5);
      check(wr_cnt == c0 + 1, "R3 strobe count", wr_cnt, c0 + 1);
      check(last_a == 5'd3, "R3 strobe addr", last_a, 3);
      check(last_d == 8'hA5, "R3 strobe data", last_d, 8'hA5);
      read_reg(5'd3, d);
      check(d == 8'hA5, "R4 R1 readback msb first", d, 8'hA5);
      cs_low();
      spi_bits(8'b00100_1_1_0, 8, rx);
      spi_bits(8'h6E, 8, rx);
      cs_high();
      read_reg(5'd4, d);
      check(d == 8'h6E, "R2 reserved bit ignored", d, 8'h6E);
   endtask

   task automatic t_multi();
      logic [7:0] rx, d0, d1;
      int c0 = wr_cnt;
      cs_low();
      spi_bits(cmd(5'd7, 1'b1, 1'b0), 8, rx);
      spi_bits(8'h11, 8, rx);
      spi_bits(8'h22, 8, rx);
      spi_bits(8'hC3, 8, rx);
      cs_high();
      check(wr_cnt == c0 + 3, "R3 multi strobes", wr_cnt, c0 + 3);
      cs_low();
      spi_bits(cmd(5'd7, 1'b0, 1'b0), 8, rx);
      spi_bits(8'h00, 8, d0);
      spi_bits(8'h00, 8, d1);
      cs_high();
      check(d0 == 8'hC3, "R4 multi read byte0", d0, 8'hC3);
      check(d1 == 8'hC3, "R4 multi read byte1", d1, 8'hC3);
   endtask

   task automatic t_full_duplex();
      logic [7:0] rx;
      full_duplex = 1'b1;
      usb_status = 8'b1011_0010;
      cs_low();
      spi_bits(cmd(5'd0, 1'b0, 1'b0), 8, rx);
      cs_high();
      check(rx == 8'hB2, "R6 status byte", rx, 8'hB2);
      usb_status = 8'h4D;
      cs_low();
      spi_bits(cmd(5'd1, 1'b0, 1'b0), 8, rx);
      cs_high();
      check(rx == 8'h4D, "R6 status byte 2", rx, 8'h4D);
   endtask

   task automatic t_half_duplex();
      logic [7:0] rx;
      full_duplex = 1'b0;
      usb_status = 8'hFF;
      cs_low();
      spi_bits(cmd(5'd0, 1'b0, 1'b0), 8, rx);
      cs_high();
      check(rx == 8'h00, "R7 no status", rx, 0);
   endtask

   task automatic t_ack();
      logic [7:0] rx, d;
      cs_low();
      spi_bits(cmd(5'd9, 1'b0, 1'b1), 8, rx);
      spi_bits(8'h00, 8, d);
      cs_high();
      check(d == 8'h01, "R5 ack set", d, 1);
      write_reg(5'd9, 8'h00);
      read_reg(5'd9, d);
      check(d == 8'h00, "R5 ack clear no request", d, 0);
   endtask

   task automatic t_gpin();
      logic [7:0] d;
      gp_in = 4'b1001;
      write_reg(5'd20, 8'hFF);
      read_reg(5'd20, d);
      check(d == 8'h9F, "R8 pins and low bits", d, 8'h9F);
      gp_in = 4'b0110;
      repeat (4) @(negedge clk);
      read_reg(5'd20, d);
      check(d == 8'h6F, "R8 pins follow", d, 8'h6F);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      int c0 = wr_cnt;
      write_reg(5'd25, 8'h5A);
      check(wr_cnt == c0, "R9 no strobe", wr_cnt, c0);
      read_reg(5'd25, d);
      check(d == 8'h00, "R9 read zero", d, 0);
      read_reg(5'd31, d);
      check(d == 8'h00, "R9 top reads zero", d, 0);
      read_reg(5'd5, d);
      check(d == 8'h00, "R9 no alias", d, 0);
   endtask

   task automatic t_abort();
      logic [7:0] rx, d;
      int c0 = wr_cnt;
      cs_low();
      spi_bits(8'hF0, 4, rx);
      cs_high();
      write_reg(5'd2, 8'h3C);
      check(wr_cnt == c0 + 1, "R10 one strobe", wr_cnt, c0 + 1);
      check(last_a == 5'd2, "R10 realigned addr", last_a, 2);
      read_reg(5'd2, d);
      check(d == 8'h3C, "R10 readback", d, 8'h3C);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("[TB] FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_write_read();
      t_multi();
      t_full_duplex();
      t_half_duplex();
      t_ack();
      t_gpin();
      t_unmapped();
      t_abort();
      finish_run();
   end
endmodule